// File: doc/BRIEF.md
# Polled Interrupt Vectoring Controller

This block arbitrates and vectors interrupts for a small single-issue 8-bit processor. Every cycle it registers the raw interrupt flag vector. It makes a decision only in the final clock of each instruction, which the core marks with an end-of-instruction strobe. That decision uses the flag values registered one cycle earlier, the per-source enables, a global enable and a two-bit priority level for each source. When a request wins and nothing blocks it, the block injects a hardware subroutine call. The call lasts a fixed four cycles. During it the block presents the service-routine address and gives a one-cycle acknowledge to the winning source, so that an edge-type flag can be cleared.

Blocking has two causes. The first is a service routine of equal or higher level that is still in service; a bit per level tracks this. The second is that the finishing instruction is a return-from-interrupt or a write to the enable or priority registers. A blocked request is not remembered. It is considered again only if its flag is still present at a later poll.

Control is a two-state machine. ST_RUN is normal execution, in which polls happen. ST_CALL covers the four cycles of the injected call. The transition ST_RUN→ST_CALL is taken on an accepted poll. ST_CALL→ST_CALL is taken while the call counter is below its last value. ST_CALL→ST_RUN is taken on the fourth call cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `call_req` is 0, `src_ack` is all zeros and `vec_addr` is 0x0000.
- R2: Arbitration happens only in a cycle where `instr_last`=1, and it uses the flags registered at the previous clock edge. A flag that first appears in the polling cycle itself is not taken by that poll.
- R3: An accepted poll raises `call_req` in the next cycle and holds it for exactly 4 cycles. In the first of those cycles the winner's bit of `src_ack` is 1 for one cycle only. A flag set in cycle 0 and polled in cycle 1 therefore gives call cycles 2 to 5.
- R4: While the call runs, `vec_addr` equals 0x0003 + 8*n for the winning source n, where bit n of every per-source vector belongs to source n.
- R5: A source takes part only when its `en_mask` bit is 1 and `glob_en` is 1. With `glob_en`=0, no call is made whatever the flags are.
- R6: The level of source n is {`prio_hi`[n], `prio_lo`[n]}, where 3 is the highest and 0 the lowest. The highest level wins. Among sources on the same level, the lowest-numbered source wins.
- R7: A pending request is refused while a level equal to or above its own is in service. A request of a strictly higher level nests above it.
- R8: A poll in which `instr_reti`=1 or `instr_cfg_wr`=1 makes no call, so at least one more instruction ends before any vector is taken.
- R9: A request refused at one poll, whose flag has dropped by the next poll, is never serviced.
- R10: A poll with `instr_reti`=1 clears only the highest level in service. Lower levels stay in service.
- R11: `instr_last` is ignored during the call. No poll happens in any ST_CALL cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_flags | input | N_SRC | Raw interrupt flags, bit n = source n |
| en_mask | input | N_SRC | Per-source enable |
| glob_en | input | 1 | Global interrupt enable |
| prio_lo | input | N_SRC | Low bit of each source's level |
| prio_hi | input | N_SRC | High bit of each source's level |
| instr_last | input | 1 | Final clock of the current instruction |
| instr_reti | input | 1 | Current instruction is a return-from-interrupt |
| instr_cfg_wr | input | 1 | Current instruction writes the enable or priority registers |
| call_req | output | 1 | Hardware call in progress |
| vec_addr | output | VEC_W | Service-routine address of the last accepted source |
| src_ack | output | N_SRC | One-cycle acknowledge, one bit per source |

## Verification
Several properties are checked on every cycle:
- each call lasts exactly four cycles;
- a call only starts after an unblocked poll with the global enable on;
- the acknowledge is at most one-hot, appears only on the first call cycle, and belongs to a source that was both enabled and flagged at the right sampling point;
- the vector matches the acknowledged source.

Some properties depend on history, and only the bench's scenarios show them:
- the level and tie ordering;
- refusal by an in-service level and nesting above it;
- clearing one in-service level per return;
- forgetting a refused request whose flag has dropped;
- ignoring a flag that arrives in the polling cycle itself.

// File: rtl/pivc_pkg.sv
package pivc_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_CALL = 1'b1
    } pivc_state_e;
endpackage

// File: rtl/irq_flag_sampler.sv
module irq_flag_sampler #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flags_in,
    output logic [N_SRC-1:0] flags_q
);
    // The poll looks at the value captured one edge earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_in;
    end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import pivc_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] flags_q,
    input  logic [N_SRC-1:0] en_mask,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] prio_lo,
    input  logic [N_SRC-1:0] prio_hi,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output lvl_t             win_lvl
);
    logic [N_SRC-1:0] pend;
    lvl_t             src_lvl [N_SRC];

    assign pend = flags_q & en_mask & {N_SRC{glob_en}};

    for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
        assign src_lvl[g] = {prio_hi[g], prio_lo[g]};
    end

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!win_valid || src_lvl[i] >= win_lvl)) begin
                win_valid = 1'b1;
                win_lvl   = src_lvl[i];
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_service_tracker.sv
module irq_service_tracker
    import pivc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  lvl_t set_lvl,
    input  logic clr_en,
    output logic svc_any,
    output lvl_t svc_top
);
    logic [NUM_LVL-1:0] in_svc_q;
    logic [NUM_LVL-1:0] top_oh;

    always_comb begin
        svc_any = 1'b0;
        svc_top = '0;
        top_oh  = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (in_svc_q[l]) begin
                svc_any = 1'b1;
                svc_top = lvl_t'(l);
            end
        end
        if (svc_any) top_oh[svc_top] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_svc_q <= '0;
        end else if (set_en) begin
            in_svc_q[set_lvl] <= 1'b1;
        end else if (clr_en) begin
            in_svc_q <= in_svc_q & ~top_oh;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import pivc_pkg::*;
#(
    parameter int              N_SRC      = 6,
    parameter int              VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0003,
    parameter int              VEC_STRIDE = 8,
    parameter int              CALL_LEN   = 4,
    localparam int             IDX_W      = $clog2(N_SRC),
    localparam int             CNT_W      = $clog2(CALL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_flags,
    input  logic [N_SRC-1:0] en_mask,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] prio_lo,
    input  logic [N_SRC-1:0] prio_hi,
    input  logic             instr_last,
    input  logic             instr_reti,
    input  logic             instr_cfg_wr,
    output logic             call_req,
    output logic [VEC_W-1:0] vec_addr,
    output logic [N_SRC-1:0] src_ack
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CALL_LEN - 1);

    pivc_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;

    logic [N_SRC-1:0] flags_q;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic             svc_any;
    lvl_t             svc_top;
    logic             poll, blocked, accept;

    irq_flag_sampler #(.N_SRC(N_SRC)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_in (irq_flags),
        .flags_q  (flags_q)
    );

    irq_level_arbiter #(.N_SRC(N_SRC)) u_arb (
        .flags_q   (flags_q),
        .en_mask   (en_mask),
        .glob_en   (glob_en),
        .prio_lo   (prio_lo),
        .prio_hi   (prio_hi),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irq_service_tracker u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_lvl (win_lvl),
        .clr_en  (poll && instr_reti),
        .svc_any (svc_any),
        .svc_top (svc_top)
    );

    // Polls exist only in normal execution; the call itself is never polled.
    assign poll    = (state_q == ST_RUN) && instr_last;
    assign blocked = instr_reti || instr_cfg_wr || (svc_any && (win_lvl <= svc_top));
    assign accept  = poll && win_valid && !blocked;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (accept)           state_d = ST_CALL;
            ST_CALL: if (cnt_q == CNT_LAST) state_d = ST_RUN;
            default:                       state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            idx_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CALL) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
            if (accept) begin
                idx_q <= win_idx;
                vec_q <= VEC_BASE + VEC_W'(VEC_STRIDE) * VEC_W'(win_idx);
            end
        end
    end

    always_comb begin
        call_req = (state_q == ST_CALL);
        vec_addr = vec_q;
        for (int i = 0; i < N_SRC; i++) begin
            src_ack[i] = call_req && (cnt_q == '0) && (idx_q == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int               N_SRC      = 6,
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0003,
    parameter int               VEC_STRIDE = 8,
    parameter int               CALL_LEN   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_flags,
    input logic [N_SRC-1:0] en_mask,
    input logic             glob_en,
    input logic             instr_last,
    input logic             instr_reti,
    input logic             instr_cfg_wr,
    input logic             call_req,
    input logic [VEC_W-1:0] vec_addr,
    input logic [N_SRC-1:0] src_ack
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 0;
        else if (call_req) run_q <= run_q + 1;
        else               run_q <= 0;
    end

    function automatic logic [VEC_W-1:0] exp_vec(input logic [N_SRC-1:0] a);
        exp_vec = '0;
        for (int i = 0; i < N_SRC; i++)
            if (a[i]) exp_vec = VEC_BASE + VEC_W'(VEC_STRIDE * i);
    endfunction

    assert_call_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (run_q < CALL_LEN));

    assert_call_full_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(call_req) |-> (run_q == CALL_LEN));

    assert_call_after_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(instr_last && !instr_reti && !instr_cfg_wr));

    assert_call_needs_glob_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(glob_en));

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));

    assert_ack_first_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack != '0) |-> $rose(call_req));

    assert_ack_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack != '0) |-> (($past(en_mask) & src_ack) != '0));

    assert_ack_prev_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack != '0) |-> (($past(irq_flags, 2) & src_ack) != '0));

    assert_vec_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack != '0) |-> (vec_addr == exp_vec(src_ack)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE), .CALL_LEN(CALL_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_flags(irq_flags), .en_mask(en_mask),
    .glob_en(glob_en), .instr_last(instr_last), .instr_reti(instr_reti),
    .instr_cfg_wr(instr_cfg_wr), .call_req(call_req), .vec_addr(vec_addr),
    .src_ack(src_ack)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] flags = '0, en = '1, lo = '0, hi = '0;
    logic       glob = 1'b1, last = 1'b0, reti = 1'b0, cfgw = 1'b0;
    logic       call_req;
    logic [15:0] vec_addr;
    logic [5:0] src_ack;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_flags(flags), .en_mask(en),
        .glob_en(glob), .prio_lo(lo), .prio_hi(hi), .instr_last(last),
        .instr_reti(reti), .instr_cfg_wr(cfgw), .call_req(call_req),
        .vec_addr(vec_addr), .src_ack(src_ack)
    );

    // {flags, en, lo, hi, glob, reti, cfg, exp_call, exp_idx}
    localparam logic [30:0] VECS [NV] = '{
        {6'b000001, 6'b111111, 6'b000000, 6'b000000, 3'b100, 1'b1, 3'd0}, // R4 base
        {6'b100100, 6'b111111, 6'b000000, 6'b000000, 3'b100, 1'b1, 3'd2}, // R6 tie
        {6'b100100, 6'b111111, 6'b000000, 6'b100000, 3'b100, 1'b1, 3'd5}, // R6 level
        {6'b000110, 6'b111111, 6'b000010, 6'b000100, 3'b100, 1'b1, 3'd2}, // R6 L2>L1
        {6'b000011, 6'b111111, 6'b000000, 6'b000000, 3'b000, 1'b0, 3'd0}, // R5 global off
        {6'b000011, 6'b111110, 6'b000000, 6'b000000, 3'b100, 1'b1, 3'd1}, // R5 masked
        {6'b001000, 6'b111111, 6'b000000, 6'b000000, 3'b110, 1'b0, 3'd0}, // R8 return
        {6'b001000, 6'b111111, 6'b000000, 6'b000000, 3'b101, 1'b0, 3'd0}, // R8 cfg write
        {6'b011000, 6'b111111, 6'b010000, 6'b011000, 3'b100, 1'b1, 3'd4}, // R6 L3>L2
        {6'b111111, 6'b111111, 6'b111111, 6'b111111, 3'b100, 1'b1, 3'd0}  // R6 all L3
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_poll(input logic [5:0] f, input logic r, input logic c,
                           input logic ec, input int ei, input string tag);
        @(negedge clk); flags = f; last = 0; reti = 0; cfgw = 0;
        @(negedge clk); last = 1; reti = r; cfgw = c;
        @(negedge clk); last = 0; reti = 0; cfgw = 0; flags = '0;
        if (ec) begin
            chk(call_req == 1'b1, tag, "call_req", 32'(call_req), 1);
            chk(src_ack == 6'(1 << ei), tag, "src_ack", 32'(src_ack), 32'(1 << ei));
            chk(vec_addr == 16'(3 + 8 * ei), {tag, " R4"}, "vec_addr", 32'(vec_addr), 32'(3 + 8 * ei));
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(call_req == 1'b1 && src_ack == '0, "R3", "call body",
                    32'({call_req, src_ack}), 32'h40);
            end
            @(negedge clk);
            chk(call_req == 1'b0, "R3", "call end", 32'(call_req), 0);
        end else begin
            chk(call_req == 1'b0 && src_ack == '0, tag, "no call",
                32'({call_req, src_ack}), 0);
        end
    endtask

    task automatic do_reti();
        @(negedge clk); last = 1; reti = 1; flags = '0;
        @(negedge clk); last = 0; reti = 0;
        chk(call_req == 1'b0, "R10", "return poll makes no call", 32'(call_req), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(call_req == 0 && src_ack == 0 && vec_addr == 0, "R1", "in reset",
            32'({call_req, src_ack, vec_addr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(call_req == 0 && src_ack == 0 && vec_addr == 0, "R1", "after reset",
            32'({call_req, src_ack, vec_addr}), 0);

        // Table walk: R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            en = VECS[v][24:19]; lo = VECS[v][18:13]; hi = VECS[v][12:7];
            glob = VECS[v][6];
            do_poll(VECS[v][30:25], VECS[v][5], VECS[v][4], VECS[v][3],
                    int'(VECS[v][2:0]), "R4/R5/R6/R8 table");
            if (VECS[v][3]) do_reti();
        end
        en = '1; glob = 1; lo = '0; hi = '0;

        // R2: flag appearing in the polling cycle itself is not taken
        @(negedge clk); flags = '0; last = 0;
        @(negedge clk); flags = 6'b000100; last = 1;
        @(negedge clk); flags = '0; last = 0;
        chk(call_req == 0, "R2", "same-cycle flag ignored", 32'(call_req), 0);
        do_poll(6'b000000, 0, 0, 0, 0, "R2 flag gone");

        // R3 minimum latency: flag cycle 0, poll cycle 1, call cycles 2..5
        do_poll(6'b010000, 0, 0, 1, 4, "R3 minimum latency");
        do_reti();

        // R7 / R10: src1 level 1, src4 level 2
        lo = 6'b000010; hi = 6'b010000;
        do_poll(6'b000010, 0, 0, 1, 1, "R7 first accepted");
        do_poll(6'b000010, 0, 0, 0, 0, "R7 equal level refused");
        do_poll(6'b000001, 0, 0, 0, 0, "R7 lower level refused");
        do_poll(6'b010000, 0, 0, 1, 4, "R7 higher level nests");
        do_reti();
        do_poll(6'b000010, 0, 0, 0, 0, "R10 level 1 still in service");
        do_reti();
        do_poll(6'b000010, 0, 0, 1, 1, "R10 level 1 cleared");
        do_reti();

        // R9: refused by return, flag drops, never serviced
        do_poll(6'b000010, 1, 0, 0, 0, "R9 refused by return");
        do_poll(6'b000000, 0, 0, 0, 0, "R9 not remembered");
        do_poll(6'b000000, 0, 0, 0, 0, "R9 still not taken");

        // R11: instr_last held during the call is ignored
        lo = '0; hi = 6'b010000;
        @(negedge clk); flags = 6'b000001; last = 0;
        @(negedge clk); last = 1;
        @(negedge clk); flags = 6'b010000; last = 1;
        chk(call_req == 1 && src_ack == 6'b000001, "R11", "call starts",
            32'({call_req, src_ack}), 32'h41);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(call_req == 1 && src_ack == 0, "R11", "no poll in call",
                32'({call_req, src_ack}), 32'h40);
        end
        last = 0;
        @(negedge clk);
        chk(call_req == 0 && src_ack == 0, "R11", "no call after call",
            32'({call_req, src_ack}), 0);
        flags = '0;
        do_reti();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule